// File: doc/BRIEF.md
# Vector-Control Register Access Resolver

This combinational block rules on every attempt to read or write one of two vector-length control registers: one that belongs to privilege level 1 and one that belongs to level 2. It takes the instruction's system-register encoding, the privilege level the access comes from, the access direction and the enable and trap bits of the surrounding control state. It then names exactly one fate for the access: an undefined-instruction fault, a trap to a stated level with a syndrome class, completion on the level-1 register, completion on the level-2 register, or a redirect to a fixed memory slot used for nested virtualization.

The checks form a priority chain that differs by privilege level. Enable bits are tested from the least privileged level upward, and a trap always goes to the level whose bit blocked the access. A host-mode hypervisor that names the level-1 register reaches the level-2 register instead. A guest hypervisor running at level 1 under full nested virtualization has its level-1 accesses turned into memory accesses. The registers, the memory path and exception entry are outside this block. All pins are plain control and status signals with no stream handshake, and a result is valid in the same cycle as its inputs.

Top module: `vcr_access_arbiter`

## Requirements
- R1: An access matches only when op0=2'b11, crn=4'b0001, crm=4'b0010 and op2=3'b000. With these, op1=3'b000 names the level-1 register and op1=3'b100 names the level-2 register. Any other encoding raises `no_match` and drives `outcome` to zero.
- R2: For a matching access exactly one bit of `outcome` is set. The bits are: bit0 undefined, bit1 trap, bit2 level-1 register, bit3 level-2 register, bit4 memory slot. `trap_lvl` and `trap_cls` are zero unless bit1 is set. `mem_ofs` is 12'h1E0 when bit4 is set and zero otherwise.
- R3: Any matching access from level 0 is undefined, whichever register it names.
- R4: A level-1 access to the level-2 register traps to level 2 with class 8'h18 when `l2_en` and `nest_bits[0]` are both 1. Otherwise it is undefined.
- R5: At level 2, for either name, the checks run in this order. `host_mode`=0 with `l2_trap`=1 traps to level 2 with class 8'h19. Next, `host_mode`=1 with `l2_vec_en[0]`=0 traps to level 2 with class 8'h19. Last, `l3_present`=1, `l3_aa64`=1 and `l3_vec_en`=0 trap to level 3 with class 8'h19.
- R6: At level 3 an access traps to level 3 with class 8'h19 when `l3_vec_en` is 0. Otherwise it completes on the register it names.
- R7: A level-1 access to the level-1 register first traps to level 1 with class 8'h19 when `l1_vec_en[0]` is 0. Then the two level-2 checks of R5 apply, but only when `l2_en` and `l2_aa64` are both 1. Then the level-3 check of R5 applies.
- R8: A level-1 access to the level-1 register that passes R7 goes to the memory slot when `l2_en`=1, `l2_aa64`=1 and `nest_bits`=3'b111. Otherwise it completes on the level-1 register.
- R9: A level-2 access that passes R5 completes on the level-2 register when it names that register or when `host_mode` is 1. Otherwise it completes on the level-1 register.
- R10: `is_write` has no effect on `outcome`, `trap_lvl` or `trap_cls`. `acc_write` equals `is_write` when outcome bit2, bit3 or bit4 is set, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_lvl | input | 2 | Privilege level issuing the access (0 to 3) |
| enc_op0 | input | 2 | Encoding field op0 |
| enc_op1 | input | 3 | Encoding field op1, selects the register |
| enc_crn | input | 4 | Encoding field crn |
| enc_crm | input | 4 | Encoding field crm |
| enc_op2 | input | 3 | Encoding field op2 |
| is_write | input | 1 | 1 for a write, 0 for a read |
| l2_en | input | 1 | Level 2 enabled in the current security state |
| l2_aa64 | input | 1 | Level 2 runs in 64-bit state |
| l3_present | input | 1 | Level 3 is implemented |
| l3_aa64 | input | 1 | Level 3 runs in 64-bit state |
| host_mode | input | 1 | Level-2 host mode |
| l2_trap | input | 1 | Level-2 vector trap bit, used when host mode is off |
| l2_vec_en | input | 2 | Level-2 vector enable field, used when host mode is on |
| l1_vec_en | input | 2 | Level-1 vector enable field |
| l3_vec_en | input | 1 | Level-3 vector enable bit |
| nest_bits | input | 3 | Nested-virtualization controls, bit0 the base enable |
| no_match | output | 1 | Encoding names neither register |
| outcome | output | 5 | One-hot verdict, bit meanings in R2 |
| trap_lvl | output | 2 | Trap target level, valid with outcome bit1 |
| trap_cls | output | 8 | Trap syndrome class, valid with outcome bit1 |
| mem_ofs | output | 12 | Memory slot offset, valid with outcome bit4 |
| acc_write | output | 1 | Direction forwarded with a completing access |

## Verification
The bench goes after the priority order. It sets several blocking bits at once and expects the least privileged block to win. A chain tested out of order would report the wrong trap level, such as level 3 where the level-1 enable blocks the access. It also separates look-alike gates. A level-2 field with only its high bit set must still trap, which catches a design that tests the whole field. Level-2 checks must be skipped for a level-1 access when level 2 is 32-bit, which catches a design that drops the qualifier. The memory redirect must need all three nesting bits, and a level-2 access under host mode that names the level-1 register must land on the level-2 register.

// File: rtl/vcr_arb_pkg.sv
package vcr_arb_pkg;

  localparam int LVL_W = 2;
  localparam int CLS_W = 8;
  localparam int OC_W  = 5;

  // shared encoding fields of both register names
  localparam logic [1:0] ENC_OP0 = 2'b11;
  localparam logic [3:0] ENC_CRN = 4'b0001;
  localparam logic [3:0] ENC_CRM = 4'b0010;
  localparam logic [2:0] ENC_OP2 = 3'b000;
  localparam logic [2:0] OP1_L1  = 3'b000;
  localparam logic [2:0] OP1_L2  = 3'b100;

  typedef enum logic [OC_W-1:0] {
    OC_NONE   = 5'b00000,
    OC_UNDEF  = 5'b00001,
    OC_TRAP   = 5'b00010,
    OC_REG_L1 = 5'b00100,
    OC_REG_L2 = 5'b01000,
    OC_MEM    = 5'b10000
  } outcome_e;

  typedef struct packed {
    logic             fire;
    logic [LVL_W-1:0] lvl;
  } gate_res_t;

endpackage

// File: rtl/vcr_enc_decode.sv
module vcr_enc_decode
  import vcr_arb_pkg::*;
(
  input  logic [1:0] op0,
  input  logic [2:0] op1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] op2,
  output logic       hit_l1,
  output logic       hit_l2
);
  logic common_ok;

  always_comb begin
    common_ok = (op0 == ENC_OP0) && (crn == ENC_CRN) &&
                (crm == ENC_CRM) && (op2 == ENC_OP2);
    hit_l1    = common_ok && (op1 == OP1_L1);
    hit_l2    = common_ok && (op1 == OP1_L2);
  end
endmodule

// File: rtl/vcr_upper_gate.sv
// Shared level-2 then level-3 enable checks; l2_live masks the level-2 part.
module vcr_upper_gate
  import vcr_arb_pkg::*;
(
  input  logic       l2_live,
  input  logic       host_mode,
  input  logic       l2_trap,
  input  logic       l2_en_lo,
  input  logic       l3_live,
  input  logic       l3_vec_en,
  output gate_res_t  res
);
  logic l2_block;
  logic l3_block;

  always_comb begin
    l2_block = l2_live && ((!host_mode && l2_trap) || (host_mode && !l2_en_lo));
    l3_block = l3_live && !l3_vec_en;
    res      = '0;
    if (l2_block) begin
      res.fire = 1'b1;
      res.lvl  = 2'd2;
    end else if (l3_block) begin
      res.fire = 1'b1;
      res.lvl  = 2'd3;
    end
  end
endmodule

// File: rtl/vcr_result_fmt.sv
module vcr_result_fmt
  import vcr_arb_pkg::*;
#(
  parameter int              OFS_W   = 12,
  parameter logic [OFS_W-1:0] MEM_OFS = 12'h1E0
) (
  input  outcome_e          verdict,
  input  logic [LVL_W-1:0]  lvl_in,
  input  logic [CLS_W-1:0]  cls_in,
  input  logic              is_write,
  output logic [OC_W-1:0]   outcome,
  output logic [LVL_W-1:0]  trap_lvl,
  output logic [CLS_W-1:0]  trap_cls,
  output logic [OFS_W-1:0]  mem_ofs,
  output logic              acc_write
);
  logic is_trap;
  logic completes;

  always_comb begin
    is_trap   = (verdict == OC_TRAP);
    completes = (verdict == OC_REG_L1) || (verdict == OC_REG_L2) || (verdict == OC_MEM);
    outcome   = verdict;
    trap_lvl  = is_trap ? lvl_in : '0;
    trap_cls  = is_trap ? cls_in : '0;
    mem_ofs   = (verdict == OC_MEM) ? MEM_OFS : '0;
    acc_write = completes && is_write;
  end
endmodule

// File: rtl/vcr_access_arbiter.sv
module vcr_access_arbiter
  import vcr_arb_pkg::*;
#(
  parameter logic [7:0]  CLS_NEST = 8'h18,
  parameter logic [7:0]  CLS_VEC  = 8'h19,
  parameter int          OFS_W    = 12,
  parameter logic [11:0] MEM_OFS  = 12'h1E0
) (
  input  logic [1:0]  cur_lvl,
  input  logic [1:0]  enc_op0,
  input  logic [2:0]  enc_op1,
  input  logic [3:0]  enc_crn,
  input  logic [3:0]  enc_crm,
  input  logic [2:0]  enc_op2,
  input  logic        is_write,
  input  logic        l2_en,
  input  logic        l2_aa64,
  input  logic        l3_present,
  input  logic        l3_aa64,
  input  logic        host_mode,
  input  logic        l2_trap,
  input  logic [1:0]  l2_vec_en,
  input  logic [1:0]  l1_vec_en,
  input  logic        l3_vec_en,
  input  logic [2:0]  nest_bits,
  output logic        no_match,
  output logic [4:0]  outcome,
  output logic [1:0]  trap_lvl,
  output logic [7:0]  trap_cls,
  output logic [11:0] mem_ofs,
  output logic        acc_write
);
  localparam int N_GATE = 2;   // index 0: level-1 view, index 1: level-2 view
  localparam logic [2:0] NEST_FULL = 3'b111;

  logic       hit_l1, hit_l2;
  logic       l2_full, l3_full;
  gate_res_t  gate_res [N_GATE];
  outcome_e   verdict;
  logic [LVL_W-1:0] v_lvl;
  logic [CLS_W-1:0] v_cls;

  vcr_enc_decode u_dec (
    .op0(enc_op0), .op1(enc_op1), .crn(enc_crn), .crm(enc_crm), .op2(enc_op2),
    .hit_l1(hit_l1), .hit_l2(hit_l2)
  );

  assign l2_full = l2_en && l2_aa64;
  assign l3_full = l3_present && l3_aa64;

  for (genvar g = 0; g < N_GATE; g++) begin : g_gate
    localparam bit QUALIFY = (g == 0);
    logic live;
    if (QUALIFY) begin : g_q
      assign live = l2_full;
    end else begin : g_u
      assign live = 1'b1;
    end
    vcr_upper_gate u_gate (
      .l2_live(live), .host_mode(host_mode), .l2_trap(l2_trap),
      .l2_en_lo(l2_vec_en[0]), .l3_live(l3_full), .l3_vec_en(l3_vec_en),
      .res(gate_res[g])
    );
  end

  // priority chain per privilege level
  always_comb begin
    verdict  = OC_NONE;
    v_lvl    = '0;
    v_cls    = '0;
    no_match = !(hit_l1 || hit_l2);
    if (!no_match) begin
      unique case (cur_lvl)
        2'd0: verdict = OC_UNDEF;
        2'd1: begin
          if (hit_l2) begin
            if (l2_en && nest_bits[0]) begin
              verdict = OC_TRAP; v_lvl = 2'd2; v_cls = CLS_NEST;
            end else begin
              verdict = OC_UNDEF;
            end
          end else if (!l1_vec_en[0]) begin
            verdict = OC_TRAP; v_lvl = 2'd1; v_cls = CLS_VEC;
          end else if (gate_res[0].fire) begin
            verdict = OC_TRAP; v_lvl = gate_res[0].lvl; v_cls = CLS_VEC;
          end else if (l2_full && nest_bits == NEST_FULL) begin
            verdict = OC_MEM;
          end else begin
            verdict = OC_REG_L1;
          end
        end
        2'd2: begin
          if (gate_res[1].fire) begin
            verdict = OC_TRAP; v_lvl = gate_res[1].lvl; v_cls = CLS_VEC;
          end else if (hit_l2 || host_mode) begin
            verdict = OC_REG_L2;
          end else begin
            verdict = OC_REG_L1;
          end
        end
        default: begin
          if (!l3_vec_en) begin
            verdict = OC_TRAP; v_lvl = 2'd3; v_cls = CLS_VEC;
          end else begin
            verdict = hit_l2 ? OC_REG_L2 : OC_REG_L1;
          end
        end
      endcase
    end
  end

  vcr_result_fmt #(.OFS_W(OFS_W), .MEM_OFS(MEM_OFS)) u_fmt (
    .verdict(verdict), .lvl_in(v_lvl), .cls_in(v_cls), .is_write(is_write),
    .outcome(outcome), .trap_lvl(trap_lvl), .trap_cls(trap_cls),
    .mem_ofs(mem_ofs), .acc_write(acc_write)
  );
endmodule

// File: rtl/vcr_access_arbiter_chk.sv
module vcr_access_arbiter_chk (
  input logic [1:0]  cur_lvl,
  input logic        is_write,
  input logic        l3_vec_en,
  input logic [2:0]  nest_bits,
  input logic        no_match,
  input logic [4:0]  outcome,
  input logic [1:0]  trap_lvl,
  input logic [7:0]  trap_cls,
  input logic [11:0] mem_ofs,
  input logic        acc_write
);
  always_comb begin
    p_nomatch_r1: assert (!no_match || outcome == 5'b0)
      else $error("no_match with nonzero outcome");
    p_onehot_r2: assert (no_match || $countones(outcome) == 1)
      else $error("outcome not one-hot");
    p_fields_r2: assert (outcome[1] || (trap_lvl == 2'd0 && trap_cls == 8'd0))
      else $error("trap fields set without trap");
    p_lvl0_r3: assert (no_match || cur_lvl != 2'd0 || outcome == 5'b00001)
      else $error("level 0 access not undefined");
    p_nestcls_r4: assert (!(outcome[1] && trap_cls == 8'h18) || (cur_lvl == 2'd1 && trap_lvl == 2'd2))
      else $error("nesting class outside level-1 to level-2 trap");
    p_upward_r5: assert (!outcome[1] || (trap_lvl >= cur_lvl && trap_lvl != 2'd0))
      else $error("trap to a lower level");
    p_l3_r6: assert (no_match || cur_lvl != 2'd3 ||
                     (l3_vec_en ? !outcome[1] : (outcome[1] && trap_lvl == 2'd3)))
      else $error("level 3 enable not honoured");
    p_mem_r8: assert (!outcome[4] || (cur_lvl == 2'd1 && nest_bits == 3'b111 && mem_ofs == 12'h1E0))
      else $error("memory redirect without full nesting");
    p_write_r10: assert (!acc_write || (is_write && outcome[4:2] != 3'b0))
      else $error("write forwarded on a failed access");
  end
endmodule

bind vcr_access_arbiter vcr_access_arbiter_chk u_chk (
  .cur_lvl(cur_lvl), .is_write(is_write), .l3_vec_en(l3_vec_en),
  .nest_bits(nest_bits), .no_match(no_match), .outcome(outcome),
  .trap_lvl(trap_lvl), .trap_cls(trap_cls), .mem_ofs(mem_ofs),
  .acc_write(acc_write)
);

// File: tb/vcr_access_arbiter_tb.sv
module vcr_access_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 20000;
  localparam int N_SWEEP = 1500;

  typedef struct packed {
    logic [1:0] lvl;
    logic [1:0] sel;      // 0 level-1 name, 1 level-2 name, 2 bad encoding
    logic [1:0] bad_kind;
    logic       wr;
    logic       l2_en, l2_aa64, l3_p, l3_aa64, host, tz;
    logic [1:0] zen, l1en;
    logic       ez;
    logic [2:0] nv;
  } ctl_t;

  typedef struct {
    logic        no_match;
    logic [4:0]  outcome;
    logic [1:0]  lvl;
    logic [7:0]  cls;
    logic [11:0] ofs;
    logic        wr;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic [1:0]  cur_lvl, enc_op0;
  logic [2:0]  enc_op1, enc_op2;
  logic [3:0]  enc_crn, enc_crm;
  logic        is_write, l2_en, l2_aa64, l3_present, l3_aa64, host_mode, l2_trap, l3_vec_en;
  logic [1:0]  l2_vec_en, l1_vec_en;
  logic [2:0]  nest_bits;
  logic        no_match, acc_write;
  logic [4:0]  outcome;
  logic [1:0]  trap_lvl;
  logic [7:0]  trap_cls;
  logic [11:0] mem_ofs;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vcr_access_arbiter u_dut (
    .cur_lvl(cur_lvl), .enc_op0(enc_op0), .enc_op1(enc_op1), .enc_crn(enc_crn),
    .enc_crm(enc_crm), .enc_op2(enc_op2), .is_write(is_write), .l2_en(l2_en),
    .l2_aa64(l2_aa64), .l3_present(l3_present), .l3_aa64(l3_aa64),
    .host_mode(host_mode), .l2_trap(l2_trap), .l2_vec_en(l2_vec_en),
    .l1_vec_en(l1_vec_en), .l3_vec_en(l3_vec_en), .nest_bits(nest_bits),
    .no_match(no_match), .outcome(outcome), .trap_lvl(trap_lvl),
    .trap_cls(trap_cls), .mem_ofs(mem_ofs), .acc_write(acc_write)
  );

  function automatic ctl_t open_ctl(logic [1:0] lvl, logic [1:0] sel);
    ctl_t c;
    c = '0;
    c.lvl = lvl; c.sel = sel;
    c.l2_en = 1; c.l2_aa64 = 1; c.l3_p = 1; c.l3_aa64 = 1;
    c.zen = 2'b11; c.l1en = 2'b11; c.ez = 1;
    return c;
  endfunction

  function automatic exp_t model(ctl_t c, string tag);
    exp_t e;
    logic l2q, l3q;
    e.no_match = (c.sel >= 2); e.outcome = 5'b0; e.lvl = 0; e.cls = 0;
    e.ofs = 0; e.wr = 0; e.tag = tag;
    l2q = c.l2_en && c.l2_aa64;
    l3q = c.l3_p && c.l3_aa64;
    if (!e.no_match) begin
      if (c.lvl == 0) e.outcome = 5'b00001;
      else if (c.lvl == 1 && c.sel == 1) begin
        if (c.l2_en && c.nv[0]) begin e.outcome = 5'b00010; e.lvl = 2; e.cls = 8'h18; end
        else e.outcome = 5'b00001;
      end else if (c.lvl == 1) begin
        if (!c.l1en[0]) begin e.outcome = 5'b00010; e.lvl = 1; e.cls = 8'h19; end
        else if (l2q && ((!c.host && c.tz) || (c.host && !c.zen[0]))) begin
          e.outcome = 5'b00010; e.lvl = 2; e.cls = 8'h19; end
        else if (l3q && !c.ez) begin e.outcome = 5'b00010; e.lvl = 3; e.cls = 8'h19; end
        else if (l2q && c.nv == 3'b111) e.outcome = 5'b10000;
        else e.outcome = 5'b00100;
      end else if (c.lvl == 2) begin
        if ((!c.host && c.tz) || (c.host && !c.zen[0])) begin
          e.outcome = 5'b00010; e.lvl = 2; e.cls = 8'h19; end
        else if (l3q && !c.ez) begin e.outcome = 5'b00010; e.lvl = 3; e.cls = 8'h19; end
        else if (c.sel == 1 || c.host) e.outcome = 5'b01000;
        else e.outcome = 5'b00100;
      end else begin
        if (!c.ez) begin e.outcome = 5'b00010; e.lvl = 3; e.cls = 8'h19; end
        else e.outcome = (c.sel == 1) ? 5'b01000 : 5'b00100;
      end
    end
    if (e.outcome == 5'b10000) e.ofs = 12'h1E0;
    e.wr = c.wr && (e.outcome[4:2] != 3'b0);
    return e;
  endfunction

  // driver: applies one vector per cycle and queues its expected result
  task automatic drive(ctl_t c, string tag);
    @(posedge clk);
    cur_lvl = c.lvl; is_write = c.wr;
    enc_op0 = 2'b11; enc_op1 = (c.sel == 1) ? 3'b100 : 3'b000;
    enc_crn = 4'b0001; enc_crm = 4'b0010; enc_op2 = 3'b000;
    if (c.sel >= 2) begin
      case (c.bad_kind)
        2'd0: enc_op1 = 3'b001;
        2'd1: enc_crm = 4'b0011;
        2'd2: enc_op0 = 2'b10;
        default: enc_op2 = 3'b001;
      endcase
    end
    l2_en = c.l2_en; l2_aa64 = c.l2_aa64; l3_present = c.l3_p; l3_aa64 = c.l3_aa64;
    host_mode = c.host; l2_trap = c.tz; l2_vec_en = c.zen; l1_vec_en = c.l1en;
    l3_vec_en = c.ez; nest_bits = c.nv;
    sb_q.push_back(model(c, tag));
  endtask

  // monitor: compares at the falling edge, after inputs have settled
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if ({no_match, outcome, trap_lvl, trap_cls, mem_ofs, acc_write} !==
            {e.no_match, e.outcome, e.lvl, e.cls, e.ofs, e.wr}) begin
          failures++;
          $display("FAIL %s: got nm=%0b oc=%b lvl=%0d cls=%h ofs=%h wr=%0b exp nm=%0b oc=%b lvl=%0d cls=%h ofs=%h wr=%0b",
                   e.tag, no_match, outcome, trap_lvl, trap_cls, mem_ofs, acc_write,
                   e.no_match, e.outcome, e.lvl, e.cls, e.ofs, e.wr);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    ctl_t c;
    // R1: idle vector with a foreign encoding
    c = open_ctl(2, 2); c.bad_kind = 0; drive(c, "R1 op1 mismatch");
    c.bad_kind = 1; drive(c, "R1 crm mismatch");
    c.bad_kind = 2; drive(c, "R1 op0 mismatch");
    c.bad_kind = 3; drive(c, "R1 op2 mismatch");
    // R3
    c = open_ctl(0, 0); drive(c, "R3 level0 level-1 name");
    c = open_ctl(0, 1); drive(c, "R3 level0 level-2 name");
    // R4
    c = open_ctl(1, 1); c.nv = 3'b001; drive(c, "R4 nesting trap 0x18");
    c.l2_en = 0; drive(c, "R4 level2 off undefined");
    c = open_ctl(1, 1); drive(c, "R4 nesting off undefined");
    // R5 ordering
    c = open_ctl(2, 1); c.tz = 1; c.ez = 0; drive(c, "R5 trap bit beats level3");
    c = open_ctl(2, 1); c.host = 1; c.zen = 2'b10; c.tz = 1; drive(c, "R5 enable low bit clear");
    c = open_ctl(2, 1); c.host = 1; c.zen = 2'b01; c.tz = 1; c.ez = 0; drive(c, "R5 level3 trap");
    c = open_ctl(2, 1); c.l3_aa64 = 0; c.ez = 0; drive(c, "R5 level3 32-bit skipped");
    // R6
    c = open_ctl(3, 0); c.ez = 0; c.tz = 1; drive(c, "R6 level3 disabled");
    c = open_ctl(3, 0); c.l1en = 0; drive(c, "R6 level3 level-1 reg");
    c = open_ctl(3, 1); drive(c, "R6 level3 level-2 reg");
    // R7
    c = open_ctl(1, 0); c.l1en = 2'b10; c.tz = 1; c.ez = 0; drive(c, "R7 level1 enable first");
    c = open_ctl(1, 0); c.tz = 1; c.ez = 0; drive(c, "R7 level2 trap before level3");
    c = open_ctl(1, 0); c.tz = 1; c.l2_aa64 = 0; c.ez = 0; drive(c, "R7 level2 32-bit skipped");
    c = open_ctl(1, 0); c.host = 1; c.zen = 2'b10; drive(c, "R7 host enable low bit");
    // R8
    c = open_ctl(1, 0); c.nv = 3'b111; drive(c, "R8 memory slot");
    c = open_ctl(1, 0); c.nv = 3'b011; drive(c, "R8 partial nesting");
    c = open_ctl(1, 0); c.nv = 3'b111; c.l2_en = 0; drive(c, "R8 level2 off");
    c = open_ctl(1, 0); c.nv = 3'b111; c.ez = 0; drive(c, "R8 trap wins over slot");
    // R9
    c = open_ctl(2, 0); c.host = 1; c.zen = 2'b01; drive(c, "R9 host redirect");
    c = open_ctl(2, 0); drive(c, "R9 no host level-1 reg");
    // R10: same vector read then write
    c = open_ctl(2, 1); c.wr = 0; drive(c, "R10 read");
    c.wr = 1; drive(c, "R10 write");
    c = open_ctl(2, 1); c.tz = 1; c.wr = 1; drive(c, "R10 write on trap");
    c = open_ctl(1, 0); c.nv = 3'b111; c.wr = 1; drive(c, "R10 write to slot");
    // R2: broad sweep of control patterns
    for (int i = 0; i < N_SWEEP; i++) begin
      c = ctl_t'($urandom());
      if (c.sel == 3) c.sel = (i % 2 == 0) ? 2'd0 : 2'd1;
      drive(c, "R2 sweep");
    end
    while (sb_q.size() > 0) @(posedge clk);
    @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule